// File: doc/BRIEF.md
# SD Error-Detection Packet CRC Inserter

This block sits in a standard-definition 10-bit video receive path, just after an ancillary-data parser. It keeps two running CRCs over every field. One covers the active-picture range and one covers the full-field range, and each range is marked by a qualifier input. At each field boundary it snapshots both results.

When the parser reports that an error-detection packet is passing, the block overwrites that packet's two CRC fields with the snapshot values. It then recomputes the packet checksum so that the packet stays well formed. The flag words inside the packet are copied through exactly as received. Packets are never created, only rewritten.

Insertion runs only in SD mode with the active-low enable asserted. In any other setting the stream passes through unchanged with the same one-cycle latency. The parser tells the block where the packet is through a packet-word strobe and a word index:

- index 0 is the DID word
- index 1 is the SDID/DBN word
- index 2 is the data count
- indices 3 to 18 are the sixteen user data words
- index 19 is the checksum

Top module: `edh_crc_inserter`

## Requirements
- R1: `vid_out` and `vid_out_vld` are registered. After a clock edge where `vid_vld` is high, `vid_out_vld` is high and `vid_out` carries the processed word. After an edge where `vid_vld` is low, `vid_out_vld` is low and `vid_out` holds its value. Reset clears both outputs to zero.
- R2: A valid word with `pkt_word` low leaves unchanged.
- R3: The active-picture CRC uses the polynomial x^16+x^12+x^5+1 with a preset of zero. For each bit of the word, taken from bit 0 to bit 9: feedback = crc[15] XOR bit; crc is shifted left by one; if feedback is set, crc is XORed with 16'h1021. The CRC runs over every valid word with `in_ap` high.
- R4: The full-field CRC uses the same algorithm as R3, over every valid word with `in_ff` high.
- R5: A valid word with `fld_start` high closes the field. Both CRCs accumulated before that word become the values inserted into packets until the next field closes. Both accumulators restart from zero, and that word counts toward the new field.
- R6: CRC word encoding, with crc split into parts.
  - Index 3/4/5 carry the active-picture CRC parts 0/1/2; index 6/7/8 carry the full-field CRC parts 0/1/2.
  - Part 0 puts crc[5:0] in bits 7:2 and part 1 puts crc[11:6] in bits 7:2. Part 2 puts crc[15:12] in bits 5:2, with bit 7 = 1 as the valid bit and bit 6 = 0.
  - In every part, bits 1:0 are 0, bit 8 is the XOR of bits 7:0, and bit 9 is the inverse of bit 8.
- R7: Packet words at indices 0 to 2 and the flag words at indices 9 to 18 are never modified.
- R8: The word at index 19 is replaced by the 9-bit sum, modulo 512, of bits 8:0 of the output words at indices 0 to 18, with bit 9 set to the inverse of bit 8.
- R9: Insertion happens only while `sd_mode` is 1 and `crc_ins_n` is 0. Otherwise packet words pass unchanged.
- R10: The insertion decision is taken at the index-0 word and held for the rest of that packet. A change of `sd_mode` or `crc_ins_n` after index 0 does not affect the packet.
- R11: A word with `vid_vld` low does not advance either CRC. It does not close a field, even when `fld_start` is high, and it does not enter the checksum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | 10 | Incoming video word |
| vid_vld | input | 1 | Incoming word is valid |
| in_ap | input | 1 | Word lies in the active-picture CRC range |
| in_ff | input | 1 | Word lies in the full-field CRC range |
| fld_start | input | 1 | Word is the first of a new field |
| pkt_word | input | 1 | Word belongs to an error-detection packet (from parser) |
| pkt_idx | input | 5 | Word index within the packet, DID = 0 |
| sd_mode | input | 1 | Stream is standard definition |
| crc_ins_n | input | 1 | Active-low insertion enable |
| vid_out | output | 10 | Outgoing video word |
| vid_out_vld | output | 1 | Outgoing word is valid |

## Verification
The bench builds the block with its package defaults: 10-bit words, 16-bit CRCs and a 5-bit packet index. With these defaults every encoded CRC word and checksum can be predicted by hand-written reference functions. Fields are kept to about thirty words, so several field closings, and the handover of each snapshot to the next packet, fit into a short run. Idle gaps carrying a stray field-start pulse are included, and mode changes are made just after the DID word, to reach the R10 and R11 corners.

// File: rtl/edh_pkg.sv
package edh_pkg;

    localparam int WORD_W = 10;
    localparam int CRC_W  = 16;
    localparam int IDX_W  = 5;
    localparam int N_RNG  = 2;
    localparam int CS_W   = 9;

    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    localparam logic [IDX_W-1:0] IDX_DID  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_AP0  = 5'd3;
    localparam logic [IDX_W-1:0] IDX_FF0  = 5'd6;
    localparam logic [IDX_W-1:0] IDX_FLG0 = 5'd9;
    localparam logic [IDX_W-1:0] IDX_CS   = 5'd19;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [CS_W-1:0]   csum_t;

    typedef enum logic [1:0] {
        SLOT_PASS,
        SLOT_AP,
        SLOT_FF,
        SLOT_CS
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic [1:0] part;
    } slot_t;

    function automatic crc_t crc_word(crc_t c, word_t w);
        crc_t r;
        logic fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = r[CRC_W-1] ^ w[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic word_t pack_udw(crc_t c, logic [1:0] part);
        logic [7:0] b;
        b = '0;
        case (part)
            2'd0:    b[7:2] = c[5:0];
            2'd1:    b[7:2] = c[11:6];
            default: begin
                b[5:2] = c[15:12];
                b[7]   = 1'b1;
            end
        endcase
        return {~(^b), ^b, b};
    endfunction

    function automatic word_t pack_csum(csum_t s);
        return {~s[CS_W-1], s};
    endfunction

    function automatic slot_t classify(logic [IDX_W-1:0] idx);
        slot_t s;
        logic [IDX_W-1:0] d;
        s.kind = SLOT_PASS;
        s.part = 2'd0;
        if (idx >= IDX_AP0 && idx < IDX_FF0) begin
            d      = idx - IDX_AP0;
            s.kind = SLOT_AP;
            s.part = d[1:0];
        end else if (idx >= IDX_FF0 && idx < IDX_FLG0) begin
            d      = idx - IDX_FF0;
            s.kind = SLOT_FF;
            s.part = d[1:0];
        end else if (idx == IDX_CS) begin
            s.kind = SLOT_CS;
        end
        return s;
    endfunction

endpackage

// File: rtl/edh_crc_accum.sv
module edh_crc_accum
    import edh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  step,
    input  logic  qual,
    input  logic  restart,
    input  word_t word,
    output crc_t  held
);

    crc_t acc_q;
    crc_t held_q;
    crc_t base;

    always_comb begin
        base = restart ? '0 : acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            held_q <= '0;
        end else if (step) begin
            if (restart) held_q <= acc_q;
            acc_q <= qual ? crc_word(base, word) : base;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/edh_pkt_rewrite.sv
module edh_pkt_rewrite
    import edh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             vld,
    input  logic             pkt,
    input  logic [IDX_W-1:0] idx,
    input  logic             live_on,
    input  crc_t             ap_crc,
    input  crc_t             ff_crc,
    input  word_t            word_in,
    output word_t            word_out,
    output logic             ins_on
);

    logic  ins_q;
    csum_t sum_q;
    slot_t slot;
    logic  at_did;

    always_comb begin
        at_did = pkt && (idx == IDX_DID);
        ins_on = at_did ? live_on : ins_q;
        slot   = classify(idx);
        word_out = word_in;
        if (pkt && ins_on) begin
            case (slot.kind)
                SLOT_AP: word_out = pack_udw(ap_crc, slot.part);
                SLOT_FF: word_out = pack_udw(ff_crc, slot.part);
                SLOT_CS: word_out = pack_csum(sum_q);
                default: word_out = word_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ins_q <= 1'b0;
            sum_q <= '0;
        end else if (vld && pkt) begin
            if (at_did) begin
                ins_q <= live_on;
                sum_q <= word_out[CS_W-1:0];
            end else begin
                sum_q <= sum_q + word_out[CS_W-1:0];
            end
        end
    end

endmodule

// File: rtl/edh_crc_inserter.sv
module edh_crc_inserter
    import edh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] vid_in,
    input  logic              vid_vld,
    input  logic              in_ap,
    input  logic              in_ff,
    input  logic              fld_start,
    input  logic              pkt_word,
    input  logic [IDX_W-1:0]  pkt_idx,
    input  logic              sd_mode,
    input  logic              crc_ins_n,
    output logic [WORD_W-1:0] vid_out,
    output logic              vid_out_vld
);

    logic [N_RNG-1:0] rng_qual;
    crc_t             rng_held [N_RNG];
    logic             live_on;
    logic             ins_eff;
    word_t            rw_word;
    logic             restart;

    assign rng_qual = {in_ff, in_ap};
    assign live_on  = sd_mode && !crc_ins_n;
    assign restart  = vid_vld && fld_start;

    for (genvar g = 0; g < N_RNG; g++) begin : g_rng
        edh_crc_accum u_acc (
            .clk     (clk),
            .rst     (rst),
            .step    (vid_vld),
            .qual    (rng_qual[g]),
            .restart (restart),
            .word    (vid_in),
            .held    (rng_held[g])
        );
    end

    edh_pkt_rewrite u_rw (
        .clk      (clk),
        .rst      (rst),
        .vld      (vid_vld),
        .pkt      (pkt_word),
        .idx      (pkt_idx),
        .live_on  (live_on),
        .ap_crc   (rng_held[0]),
        .ff_crc   (rng_held[1]),
        .word_in  (vid_in),
        .word_out (rw_word),
        .ins_on   (ins_eff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vid_out     <= '0;
            vid_out_vld <= 1'b0;
        end else begin
            vid_out_vld <= vid_vld;
            if (vid_vld) vid_out <= rw_word;
        end
    end

endmodule

// File: rtl/edh_crc_inserter_chk.sv
module edh_crc_inserter_chk
    import edh_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] vid_in,
    input logic              vid_vld,
    input logic              pkt_word,
    input logic [IDX_W-1:0]  pkt_idx,
    input logic              ins_eff,
    input logic [WORD_W-1:0] vid_out,
    input logic              vid_out_vld
);

    logic hdr_or_flag;
    logic crc_slot;
    assign hdr_or_flag = pkt_idx < IDX_AP0 || (pkt_idx >= IDX_FLG0 && pkt_idx < IDX_CS);
    assign crc_slot    = pkt_idx >= IDX_AP0 && pkt_idx < IDX_FLG0;

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) vid_vld |=> vid_out_vld); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) !vid_vld |=> (!vid_out_vld && $stable(vid_out))); // R11
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (rst) (vid_vld && !pkt_word) |=> vid_out == $past(vid_in)); // R2
    AST_HDR_FLAGS_KEPT: assert property (@(posedge clk) disable iff (rst) (vid_vld && pkt_word && hdr_or_flag) |=> vid_out == $past(vid_in)); // R7
    AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst) (vid_vld && !ins_eff) |=> vid_out == $past(vid_in)); // R9
    AST_CRC_WORD_FORM: assert property (@(posedge clk) disable iff (rst) (vid_vld && pkt_word && ins_eff && crc_slot) |=> (vid_out[9] != vid_out[8] && vid_out[1:0] == 2'b00)); // R6
    AST_CSUM_FORM: assert property (@(posedge clk) disable iff (rst) (vid_vld && pkt_word && ins_eff && pkt_idx == IDX_CS) |=> vid_out[9] != vid_out[8]); // R8

endmodule

bind edh_crc_inserter edh_crc_inserter_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .vid_in      (vid_in),
    .vid_vld     (vid_vld),
    .pkt_word    (pkt_word),
    .pkt_idx     (pkt_idx),
    .ins_eff     (ins_eff),
    .vid_out     (vid_out),
    .vid_out_vld (vid_out_vld)
);

// File: tb/edh_crc_inserter_test.sv
module edh_crc_inserter_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] vid_in;
    logic       vid_vld;
    logic       in_ap;
    logic       in_ff;
    logic       fld_start;
    logic       pkt_word;
    logic [4:0] pkt_idx;
    logic       sd_mode;
    logic       crc_ins_n;
    logic [9:0] vid_out;
    logic       vid_out_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] cur_ap, cur_ff, prev_ap, prev_ff;

    always #2.5 clk = ~clk;

    edh_crc_inserter uut (
        .clk(clk), .rst(rst), .vid_in(vid_in), .vid_vld(vid_vld),
        .in_ap(in_ap), .in_ff(in_ff), .fld_start(fld_start),
        .pkt_word(pkt_word), .pkt_idx(pkt_idx), .sd_mode(sd_mode),
        .crc_ins_n(crc_ins_n), .vid_out(vid_out), .vid_out_vld(vid_out_vld)
    );

    function automatic logic [15:0] ref_crc(logic [15:0] c, logic [9:0] w);
        logic [15:0] r = c;
        for (int b = 0; b < 10; b++) begin
            if (r[15] ^ w[b]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [9:0] ref_udw(logic [15:0] c, int part);
        logic [7:0] v = 8'h00;
        if (part == 0)      v = {c[5:0], 2'b00};
        else if (part == 1) v = {c[11:6], 2'b00};
        else                v = {1'b1, 1'b0, c[15:12], 2'b00};
        return {~(^v), ^v, v};
    endfunction

    task automatic check(string req, logic [9:0] act, logic [9:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [9:0] w, input logic v, input logic ap, input logic ff,
                        input logic fs, input logic pw, input logic [4:0] ix,
                        output logic [9:0] o, output logic ov);
        vid_in = w; vid_vld = v; in_ap = ap; in_ff = ff;
        fld_start = fs; pkt_word = pw; pkt_idx = ix;
        @(negedge clk);
        o = vid_out; ov = vid_out_vld;
    endtask

    task automatic t_reset();
        check("R1 reset data", vid_out, 10'h000);
        check("R1 reset valid", {9'd0, vid_out_vld}, 10'h000);
    endtask

    // One field of short synthetic picture data; gaps add invalid words (R11)
    task automatic run_field(input int seed, input bit gaps);
        logic [9:0] o, w, last;
        logic ov, ap, ff;
        prev_ap = cur_ap; prev_ff = cur_ff;
        cur_ap = 16'h0; cur_ff = 16'h0;
        last = vid_out;
        for (int i = 0; i < 30; i++) begin
            w  = 10'((seed * 113 + i * 29 + i * i) & 10'h3FF);
            ap = (i % 5 != 0) && (i > 4);
            ff = (i != 7);
            if (ap) cur_ap = ref_crc(cur_ap, w);
            if (ff) cur_ff = ref_crc(cur_ff, w);
            xfer(w, 1'b1, ap, ff, i == 0, 1'b0, 5'd0, o, ov);
            check("R2 passthrough", o, w);
            check("R1 valid follows", {9'd0, ov}, 10'h001);
            last = o;
            if (gaps && (i % 6 == 3)) begin
                xfer(~w, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 5'd0, o, ov);
                check("R11 gap valid low", {9'd0, ov}, 10'h000);
                check("R11 gap output held", o, last);
            end
        end
    endtask

    // A packet preceded by ancillary flag words; checks every output word
    task automatic send_pkt(input bit exp_ins, input logic [15:0] ap, input logic [15:0] ff,
                            input bit flip, input string tag);
        logic [9:0] o, w, e;
        logic ov;
        logic [8:0] sum = 9'd0;
        xfer(10'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, o, ov); check("R2 ADF", o, 10'h000);
        xfer(10'h3FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, o, ov); check("R2 ADF", o, 10'h3FF);
        xfer(10'h3FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd0, o, ov); check("R2 ADF", o, 10'h3FF);
        for (int k = 0; k < 20; k++) begin
            if (k == 0)      w = 10'h1F4;
            else if (k == 1) w = 10'h200;
            else if (k == 2) w = 10'h110;
            else if (k < 9)  w = 10'h2AA ^ 10'(k);
            else if (k < 19) w = 10'((k * 53) & 10'h3FF);
            else             w = 10'h155;
            e = w;
            if (exp_ins && k >= 3 && k <= 5) e = ref_udw(ap, k - 3);
            if (exp_ins && k >= 6 && k <= 8) e = ref_udw(ff, k - 6);
            if (exp_ins && k == 19)          e = {~sum[8], sum};
            if (k < 19) sum = sum + e[8:0];
            xfer(w, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 5'(k), o, ov);
            if (flip && k == 0) crc_ins_n = ~crc_ins_n;
            if (k < 3)       check({tag, " R7 header"}, o, e);
            else if (k < 6)  check({tag, " R3 R6 picture crc"}, o, e);
            else if (k < 9)  check({tag, " R4 R6 field crc"}, o, e);
            else if (k < 19) check({tag, " R7 flags"}, o, e);
            else             check({tag, " R8 checksum"}, o, e);
        end
    endtask

    initial begin
        cur_ap = 16'h0; cur_ff = 16'h0; prev_ap = 16'h0; prev_ff = 16'h0;
        vid_in = 10'h0; vid_vld = 1'b0; in_ap = 1'b0; in_ff = 1'b0;
        fld_start = 1'b0; pkt_word = 1'b0; pkt_idx = 5'd0;
        sd_mode = 1'b1; crc_ins_n = 1'b0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        run_field(1, 1'b0);
        run_field(2, 1'b1);
        send_pkt(1'b1, prev_ap, prev_ff, 1'b0, "R5 first field");
        run_field(3, 1'b0);
        send_pkt(1'b1, prev_ap, prev_ff, 1'b0, "R5 restarted field");
        crc_ins_n = 1'b1;
        send_pkt(1'b0, prev_ap, prev_ff, 1'b0, "R9 disabled");
        crc_ins_n = 1'b0; sd_mode = 1'b0;
        send_pkt(1'b0, prev_ap, prev_ff, 1'b0, "R9 not sd");
        sd_mode = 1'b1; crc_ins_n = 1'b0;
        send_pkt(1'b1, prev_ap, prev_ff, 1'b1, "R10 off after DID");
        send_pkt(1'b0, prev_ap, prev_ff, 1'b1, "R10 on after DID");
        crc_ins_n = 1'b0;
        run_field(4, 1'b1);
        send_pkt(1'b1, prev_ap, prev_ff, 1'b0, "R11 gaps field");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule